// File: doc/BRIEF.md
# Sequencer Mode-Exit Controller

This block is a host-side SPI master that takes a delta-sigma converter out of whatever channel-sequencing mode it is running in. A one-cycle `start` pulse makes it send a single power-down command byte. It then reads the converter's status register over and over, one chip-select transaction per read, until the two-bit power-down status field shows that the part has settled in SLEEP or in STANDBY. At that point the controller raises `done` and reports the state that was reached on `pd_state`.

A poll budget limits the search. If that many status reads pass without a settling code, the controller raises `timeout` instead of `done` and leaves the bus idle. The following are all parameters:
- the SCLK half-period, counted in system clocks;
- the status register address;
- the bit position of the status field within the 16-bit status word;
- the poll budget;
- the minimum chip-select high gap between transactions.

Top module: `seqexit_ctrl`

## Requirements
- R1: A start pulse accepted while idle first produces exactly one 8-SCLK transaction whose byte, sent MSB first, is 0x90. The bits are: bit 7 = 1, bit 6 = 0 (conversion command), mode bits 5:4 = 01 (power-down) and rate bits 3:0 = 0000.
- R2: Each status poll is its own chip-select-low transaction of 24 SCLK cycles. It sends the byte {1, 1, STAT_ADDR[4:0], 1} MSB first: bit 6 = 1 selects register access and bit 0 = 1 selects a read. The 16 status bits are then taken from MISO, MSB first, at each rising SCLK.
- R3: Polling repeats while the status field holds 00 or 11. The first poll that returns 01 (SLEEP) or 10 (STANDBY) ends the sequence with `done` = 1 and `pd_state` equal to that code, and no further transactions follow.
- R4: The status field is bits [PD_LSB+1:PD_LSB] of the status word (default 1:0). Values in the other status bits do not end the sequence.
- R5: SCLK idles low whenever CSB is high, and MOSI does not change while SCLK is high. The first rising SCLK comes at least DIV system clocks after CSB falls. CSB rises at least DIV system clocks after the last falling SCLK.
- R6: CSB stays high for at least 2 system clocks between any two transactions.
- R7: Within a transaction, successive rising SCLK edges are exactly 2*DIV system clocks apart.
- R8: After POLL_LIMIT polls without a settling code, `timeout` rises, `done` stays low, and no further transactions occur.
- R9: `done`, `timeout` and `pd_state` hold their values until the next accepted start. An accepted start clears `done` and `timeout` and raises `busy` on the next cycle. A start that arrives while `busy` is high is ignored.
- R10: After reset: CSB = 1, SCLK = 0, MOSI = 0, `busy` = 0, `done` = 0, `timeout` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin the exit sequence |
| miso | input | 1 | Serial data from the converter |
| csb | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Converter reached SLEEP or STANDBY |
| timeout | output | 1 | Poll budget used up without a settling code |
| pd_state | output | 2 | Last power-down status field read (01 SLEEP, 10 STANDBY) |

## Verification
The bench places the settling code next to decoy bits: it returns words whose default-position bits read 01 or 10 while the field at the configured position reads 00. A design that decodes the wrong bits would therefore stop early, and the scoreboard would see missing poll frames. It also returns a 11 field before a valid code, so a decoder that treats any nonzero field as settled ends one poll too soon. It spends the full poll budget and then watches the idle bus: an off-by-one limit sends one poll too many or too few, and a controller that fails to stop keeps toggling CSB. It also sends a second start in the middle of a run, which a controller that does not guard `busy` turns into an extra command frame. The bench times the gaps around every chip-select edge, so a missing setup or hold half-period shows up as a short interval.

// File: rtl/seqexit_pkg.sv
package seqexit_pkg;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_CMD,
    CT_POLL
  } ctl_t;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_SETUP,
    SH_LOW,
    SH_HIGH,
    SH_HOLD,
    SH_GAP
  } ph_t;

  localparam logic [1:0] PD_SLEEP   = 2'b01;
  localparam logic [1:0] PD_STBY    = 2'b10;
  localparam logic [1:0] MODE_PWRDN = 2'b01;
  localparam logic [3:0] RATE_EXIT  = 4'b0000;

  // power-down conversion command: b7=1, b6=0, mode, rate
  function automatic logic [7:0] exit_cmd();
    return {1'b1, 1'b0, MODE_PWRDN, RATE_EXIT};
  endfunction

  // register read command: b7=1, b6=1, address, read flag
  function automatic logic [7:0] poll_cmd(input logic [4:0] addr);
    return {2'b11, addr, 1'b1};
  endfunction

endpackage

// File: rtl/seqexit_frame.sv
module seqexit_frame
  import seqexit_pkg::*;
#(
  parameter int         FRAME_W   = 24,
  parameter int         NBW       = 5,
  parameter logic [4:0] STAT_ADDR = 5'h00
) (
  input  logic               is_poll,
  output logic [FRAME_W-1:0] tx_word,
  output logic [NBW-1:0]     tx_bits
);

  localparam int PAD = FRAME_W - 8;

  always_comb begin
    if (is_poll) begin
      tx_word = {poll_cmd(STAT_ADDR), {PAD{1'b0}}};
      tx_bits = NBW'(FRAME_W);
    end else begin
      tx_word = {exit_cmd(), {PAD{1'b0}}};
      tx_bits = NBW'(8);
    end
  end

endmodule

// File: rtl/seqexit_spi_shift.sv
module seqexit_spi_shift
  import seqexit_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int NBW     = 5,
  parameter int DIV     = 2,
  parameter int GAP_MIN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic [NBW-1:0]     tx_bits,
  input  logic               miso,
  output logic               csb,
  output logic               sclk,
  output logic               mosi,
  output logic               samp_stb,
  output logic               samp_bit,
  output logic [NBW-1:0]     samp_idx,
  output logic               fin
);

  localparam int GAP_CLK = (GAP_MIN > DIV) ? GAP_MIN : DIV;
  localparam int CW      = $clog2(GAP_CLK + 1);

  ph_t                phase;
  logic [CW-1:0]      cnt;
  logic [CW-1:0]      lim;
  logic               tick;
  logic [NBW-1:0]     sent;
  logic [NBW-1:0]     nbits_q;
  logic [FRAME_W-1:0] sreg;

  assign lim      = (phase == SH_GAP) ? CW'(GAP_CLK - 1) : CW'(DIV - 1);
  assign tick     = (cnt == lim);
  assign samp_idx = sent;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= SH_IDLE;
      cnt      <= '0;
      csb      <= 1'b1;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      sreg     <= '0;
      sent     <= '0;
      nbits_q  <= '0;
      samp_stb <= 1'b0;
      samp_bit <= 1'b0;
      fin      <= 1'b0;
    end else begin
      fin      <= 1'b0;
      samp_stb <= 1'b0;
      if (phase == SH_IDLE) begin
        cnt <= '0;
        if (go) begin
          phase   <= SH_SETUP;
          csb     <= 1'b0;
          mosi    <= tx_word[FRAME_W-1];
          sreg    <= tx_word << 1;
          nbits_q <= tx_bits;
          sent    <= '0;
        end
      end else if (!tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        unique case (phase)
          SH_SETUP, SH_LOW: begin
            sclk     <= 1'b1;
            samp_stb <= 1'b1;
            samp_bit <= miso;
            sent     <= sent + 1'b1;
            phase    <= SH_HIGH;
          end
          SH_HIGH: begin
            sclk <= 1'b0;
            if (sent == nbits_q) begin
              phase <= SH_HOLD;
            end else begin
              phase <= SH_LOW;
              mosi  <= sreg[FRAME_W-1];
              sreg  <= sreg << 1;
            end
          end
          SH_HOLD: begin
            csb   <= 1'b1;
            mosi  <= 1'b0;
            phase <= SH_GAP;
          end
          SH_GAP: begin
            phase <= SH_IDLE;
            fin   <= 1'b1;
          end
          default: phase <= SH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/seqexit_pd_cap.sv
module seqexit_pd_cap
  import seqexit_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int NBW     = 5,
  parameter int PD_LSB  = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           samp_stb,
  input  logic           samp_bit,
  input  logic [NBW-1:0] samp_idx,
  output logic [1:0]     field,
  output logic           terminal
);

  // frame bit k (1-based, MSB first) carries status bit FRAME_W-k
  localparam int HI_IDX = FRAME_W - (PD_LSB + 1);
  localparam int LO_IDX = FRAME_W - PD_LSB;

  always_ff @(posedge clk) begin
    if (rst) begin
      field <= 2'b00;
    end else if (samp_stb) begin
      if (samp_idx == NBW'(HI_IDX)) field[1] <= samp_bit;
      if (samp_idx == NBW'(LO_IDX)) field[0] <= samp_bit;
    end
  end

  assign terminal = (field == PD_SLEEP) || (field == PD_STBY);

endmodule

// File: rtl/seqexit_ctrl.sv
module seqexit_ctrl
  import seqexit_pkg::*;
#(
  parameter int         DIV        = 2,
  parameter logic [4:0] STAT_ADDR  = 5'h00,
  parameter int         PD_LSB     = 0,
  parameter int         POLL_LIMIT = 16,
  parameter int         DATA_W     = 16,
  parameter int         GAP_MIN    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       miso,
  output logic       csb,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic       timeout,
  output logic [1:0] pd_state
);

  localparam int FRAME_W = 8 + DATA_W;
  localparam int NBW     = $clog2(FRAME_W + 1);
  localparam int PCW     = $clog2(POLL_LIMIT + 1);

  ctl_t               st;
  logic               go;
  logic               is_poll;
  logic [PCW-1:0]     polls;
  logic [FRAME_W-1:0] tx_word;
  logic [NBW-1:0]     tx_bits;
  logic               samp_stb;
  logic               samp_bit;
  logic [NBW-1:0]     samp_idx;
  logic               fin;
  logic [1:0]         field;
  logic               terminal;

  seqexit_frame #(
    .FRAME_W  (FRAME_W),
    .NBW      (NBW),
    .STAT_ADDR(STAT_ADDR)
  ) u_frame (
    .is_poll(is_poll),
    .tx_word(tx_word),
    .tx_bits(tx_bits)
  );

  seqexit_spi_shift #(
    .FRAME_W(FRAME_W),
    .NBW    (NBW),
    .DIV    (DIV),
    .GAP_MIN(GAP_MIN)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .tx_word (tx_word),
    .tx_bits (tx_bits),
    .miso    (miso),
    .csb     (csb),
    .sclk    (sclk),
    .mosi    (mosi),
    .samp_stb(samp_stb),
    .samp_bit(samp_bit),
    .samp_idx(samp_idx),
    .fin     (fin)
  );

  seqexit_pd_cap #(
    .FRAME_W(FRAME_W),
    .NBW    (NBW),
    .PD_LSB (PD_LSB)
  ) u_pd (
    .clk     (clk),
    .rst     (rst),
    .samp_stb(samp_stb),
    .samp_bit(samp_bit),
    .samp_idx(samp_idx),
    .field   (field),
    .terminal(terminal)
  );

  assign busy = (st != CT_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CT_IDLE;
      go       <= 1'b0;
      is_poll  <= 1'b0;
      polls    <= '0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      pd_state <= 2'b00;
    end else begin
      go <= 1'b0;
      unique case (st)
        CT_IDLE: begin
          if (start) begin
            done     <= 1'b0;
            timeout  <= 1'b0;
            pd_state <= 2'b00;
            polls    <= '0;
            is_poll  <= 1'b0;
            go       <= 1'b1;
            st       <= CT_CMD;
          end
        end
        CT_CMD: begin
          if (fin) begin
            is_poll <= 1'b1;
            go      <= 1'b1;
            st      <= CT_POLL;
          end
        end
        CT_POLL: begin
          if (fin) begin
            polls    <= polls + 1'b1;
            pd_state <= field;
            if (terminal) begin
              done <= 1'b1;
              st   <= CT_IDLE;
            end else if (polls == PCW'(POLL_LIMIT - 1)) begin
              timeout <= 1'b1;
              st      <= CT_IDLE;
            end else begin
              go <= 1'b1;
            end
          end
        end
        default: st <= CT_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seqexit_ctrl_chk.sv
module seqexit_ctrl_chk #(
  parameter int DIV = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       csb,
  input logic       sclk,
  input logic       busy,
  input logic       done,
  input logic       timeout,
  input logic [1:0] pd_state
);

  localparam int CW = $clog2(DIV + 4) + 1;

  logic [CW-1:0] lo_cnt;
  logic [CW-1:0] hi_cnt;
  logic [CW-1:0] sl_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      hi_cnt <= '1;
      sl_cnt <= '0;
    end else begin
      lo_cnt <= csb ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !csb ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1);
      sl_cnt <= sclk ? '0 : ((sl_cnt == '1) ? sl_cnt : sl_cnt + 1'b1);
    end
  end

  // R5
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
    csb |-> !sclk);

  // R5
  cs_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> (lo_cnt >= CW'(DIV)));

  // R5
  cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(csb) |-> (sl_cnt >= CW'(DIV)));

  // R6
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(csb) |-> (hi_cnt >= CW'(2)));

  // R3
  done_code_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (pd_state == 2'b01 || pd_state == 2'b10));

  // R8
  excl_result_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(pd_state)));

  // R9
  timeout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (timeout && !start) |=> timeout);

  // R9
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!done && !timeout));

endmodule

bind seqexit_ctrl seqexit_ctrl_chk #(.DIV(DIV)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .csb     (csb),
  .sclk    (sclk),
  .busy    (busy),
  .done    (done),
  .timeout (timeout),
  .pd_state(pd_state)
);

// File: tb/seqexit_ctrl_tb.sv
`timescale 1ns/1ps
module seqexit_ctrl_tb;

  localparam int         CLK_NS = 4;
  localparam int         DIV    = 2;
  localparam logic [4:0] ADDR   = 5'h15;
  localparam int         PDL    = 2;
  localparam int         LIMIT  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       miso = 1'b0;
  logic       csb, sclk, mosi, busy, done, timeout;
  logic [1:0] pd_state;

  int vectors = 0;
  int fails   = 0;

  always #(CLK_NS/2) clk = ~clk;

  seqexit_ctrl #(
    .DIV       (DIV),
    .STAT_ADDR (ADDR),
    .PD_LSB    (PDL),
    .POLL_LIMIT(LIMIT)
  ) u_dut (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .miso    (miso),
    .csb     (csb),
    .sclk    (sclk),
    .mosi    (mosi),
    .busy    (busy),
    .done    (done),
    .timeout (timeout),
    .pd_state(pd_state)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  int          exp_len[$];
  logic [7:0]  exp_cmd[$];
  logic [15:0] resp_q[$];

  // slave / monitor state
  bit          in_frame = 0;
  bit          had_rise = 0;
  int          rise_n, fall_n;
  int          frames_seen = 0;
  logic [7:0]  cap;
  logic [15:0] resp_cur;
  time         t_csb_fall, t_csb_rise, t_last_rise, t_last_fall;
  bit          per_ok, mosi_ok;
  bit          prev_sclk = 0;
  logic        prev_mosi = 0;
  int          idle_clk_bad = 0;

  always @(negedge csb) begin
    if (had_rise)
      check(($time - t_csb_rise) >= 2*CLK_NS, "R6", "cs high gap ns",
            $time - t_csb_rise, 2*CLK_NS);
    in_frame   = 1;
    rise_n     = 0;
    fall_n     = 0;
    cap        = 8'h00;
    miso       = 1'b0;
    per_ok     = 1;
    mosi_ok    = 1;
    t_csb_fall = $time;
  end

  always @(posedge sclk) begin
    if (in_frame) begin
      rise_n++;
      if (rise_n == 1)
        check(($time - t_csb_fall) >= DIV*CLK_NS, "R5", "cs setup ns",
              $time - t_csb_fall, DIV*CLK_NS);
      else if (($time - t_last_rise) != 2*DIV*CLK_NS)
        per_ok = 0;
      t_last_rise = $time;
      if (rise_n <= 8) cap = {cap[6:0], mosi};
      if (rise_n == 8 && cap[7:6] == 2'b11)
        resp_cur = (resp_q.size() > 0) ? resp_q.pop_front() : 16'h0000;
    end
  end

  always @(negedge sclk) begin
    if (in_frame) begin
      fall_n++;
      t_last_fall = $time;
      if (fall_n >= 8 && fall_n <= 23) miso = resp_cur[15-(fall_n-8)];
    end
  end

  // monitor: pops the expected frame and compares at the end of each frame
  always @(posedge csb) begin
    if (in_frame) begin
      in_frame = 0;
      had_rise = 1;
      t_csb_rise = $time;
      frames_seen++;
      check(($time - t_last_fall) >= DIV*CLK_NS, "R5", "cs hold ns",
            $time - t_last_fall, DIV*CLK_NS);
      check(per_ok, "R7", "sclk period uniform", per_ok, 1);
      check(mosi_ok, "R5", "mosi stable while sclk high", mosi_ok, 1);
      if (exp_len.size() == 0) begin
        check(0, "R8", "unexpected frame cmd", cap, 0);
      end else begin
        int         el;
        logic [7:0] ec;
        el = exp_len.pop_front();
        ec = exp_cmd.pop_front();
        if (el == 8) begin
          check(rise_n == 8, "R1", "command frame length", rise_n, 8);
          check(cap == ec, "R1", "command byte", cap, ec);
        end else begin
          check(rise_n == 24, "R2", "poll frame length", rise_n, 24);
          check(cap == ec, "R2", "poll byte", cap, ec);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (in_frame && sclk && prev_sclk && mosi !== prev_mosi) mosi_ok = 0;
      if (csb === 1'b1 && sclk !== 1'b0) idle_clk_bad++;
    end
    prev_sclk = sclk;
    prev_mosi = mosi;
  end

  // driver: pushes expected frames, then runs one exit sequence
  task automatic run_exit(input int n_polls, input bit extra, input bit exp_done,
                          input logic [1:0] exp_pd, input string req);
    int n;
    exp_len.push_back(8);
    exp_cmd.push_back(8'h90);
    for (int i = 0; i < n_polls; i++) begin
      exp_len.push_back(24);
      exp_cmd.push_back({2'b11, ADDR, 1'b1});
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy === 1'b1 && done === 1'b0 && timeout === 1'b0, "R9",
          "start clears results and sets busy", {busy, done, timeout}, 3'b100);
    if (extra) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (!(done === 1'b1 || timeout === 1'b1) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done === exp_done, req, "done", done, exp_done);
    check(timeout === !exp_done, req, "timeout", timeout, !exp_done);
    if (exp_done) check(pd_state === exp_pd, req, "pd_state", pd_state, exp_pd);
    check(exp_len.size() == 0, req, "expected frames left", exp_len.size(), 0);
    check(resp_q.size() == 0, req, "responses left", resp_q.size(), 0);
  endtask

  initial begin
    int seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(csb === 1'b1, "R10", "csb", csb, 1);
    check(sclk === 1'b0, "R10", "sclk", sclk, 0);
    check(mosi === 1'b0, "R10", "mosi", mosi, 0);
    check({busy, done, timeout} === 3'b000, "R10", "busy/done/timeout",
          {busy, done, timeout}, 0);

    // R3 R4: field at bits 3:2 reads 00, 11, then 01 (SLEEP)
    resp_q.push_back(16'hFFF3);
    resp_q.push_back(16'h000C);
    resp_q.push_back(16'hA5A7);
    run_exit(3, 0, 1, 2'b01, "R3");

    // R9: results hold, bus stays idle
    seen = frames_seen;
    repeat (150) @(negedge clk);
    check(done === 1'b1 && pd_state === 2'b01, "R9", "done/pd held",
          {done, pd_state}, 3'b101);
    check(frames_seen == seen, "R9", "no frames while idle", frames_seen, seen);

    // R4 decoys in bits 1:0, then STANDBY; R9 mid-run start ignored
    resp_q.push_back(16'h0001);
    resp_q.push_back(16'h0002);
    resp_q.push_back(16'hFFFB);
    run_exit(3, 1, 1, 2'b10, "R4");

    // R8: budget exhausted
    resp_q.push_back(16'h0000);
    resp_q.push_back(16'h0003);
    resp_q.push_back(16'h0000);
    resp_q.push_back(16'hFFF1);
    run_exit(LIMIT, 0, 0, 2'b00, "R8");
    seen = frames_seen;
    repeat (200) @(negedge clk);
    check(frames_seen == seen, "R8", "no frames after timeout", frames_seen, seen);
    check(timeout === 1'b1 && done === 1'b0, "R9", "timeout held",
          {timeout, done}, 2'b10);

    // R3: immediate STANDBY after timeout
    resp_q.push_back(16'h0008);
    run_exit(1, 0, 1, 2'b10, "R3");

    check(idle_clk_bad == 0, "R5", "sclk high with csb high", idle_clk_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * CLK_NS);
    fails++;
    vectors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule